// File: doc/BRIEF.md
# Prefix-Based Operand Register Selector

This block holds the sixteen 16-bit general registers of an accumulator-centric core. The core's 8-bit opcodes can name at most one register. Two selectors, one for the source and one for the destination, decide which registers an operating instruction reads and writes.

With no prefix in effect, both selectors point at register 0. Three prefix strobes let the decoder redirect them:
- one sets the source selector;
- one sets the destination selector;
- one sets both.

The redirection is one-shot. The next operating instruction uses the selectors, and they then fall back to register 0. A result from an external result bus is written into the register that the destination selector names.

Registers 15 (program counter) and 14 (memory-buffer pointer) behave as ordinary operands. A write into register 14 also raises a strobe that asks for a buffer reload.

Top module: `operand_select`

## Requirements
- R1: After reset all sixteen registers read 0, both selectors read 0 and `reload_o` is low.
- R2: A cycle with `pfx_src_i` high (and `pfx_both_i` low) loads `reg_field_i` into the source selector, visible on `src_idx_o` from the next cycle; the destination selector is unchanged unless `pfx_dst_i` is also high.
- R3: A cycle with `pfx_dst_i` high (and `pfx_both_i` low) loads `reg_field_i` into the destination selector from the next cycle; the source selector is unchanged unless `pfx_src_i` is also high.
- R4: A cycle with `pfx_both_i` high loads `reg_field_i` into both selectors, overriding any `pfx_src_i` or `pfx_dst_i` in the same cycle.
- R5: Prefixes stack. Over several cycles the last value written to each selector wins, and in a cycle with no strobe both selectors hold.
- R6: A cycle with `exec_i` high uses the current selectors, after which both return to 0. A prefix in that same cycle instead loads its value into the selector(s) it names for the following instruction.
- R7: A cycle with `exec_i` and `wr_en_i` high writes `wdata_i` into the register named by `dst_idx_o`, visible on `rd_data_o` from the next cycle. `exec_i` without `wr_en_i`, or `wr_en_i` without `exec_i`, changes no register.
- R8: `src_data_o` and `dst_data_o` always show the current contents of the registers named by the two selectors, and `rd_data_o` shows the register named by `rd_idx_i`.
- R9: `reload_o` is high in exactly those cycles in which a register write targets register 14.
- R10: Registers 14 and 15 can be written, read back and used as source like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfx_src_i | input | 1 | Source-override prefix strobe |
| pfx_dst_i | input | 1 | Destination-override prefix strobe |
| pfx_both_i | input | 1 | Prefix strobe overriding both selectors |
| exec_i | input | 1 | Operating (non-prefix) instruction strobe |
| wr_en_i | input | 1 | The operating instruction writes a result |
| reg_field_i | input | 4 | Register field of the decoded prefix |
| wdata_i | input | 16 | External result bus |
| rd_idx_i | input | 4 | Index for the observation read port |
| src_idx_o | output | 4 | Current source selector |
| dst_idx_o | output | 4 | Current destination selector |
| src_data_o | output | 16 | Contents of the source register |
| dst_data_o | output | 16 | Contents of the destination register |
| rd_data_o | output | 16 | Contents of register `rd_idx_i` |
| reload_o | output | 1 | Buffer reload request on a write to register 14 |

## Verification
The interesting collision is an operating instruction and a new prefix arriving in the same cycle. The instruction must write through the old destination, while the selectors are loaded from the prefix rather than cleared. A second collision is both-prefix and single-prefix together, where the both-prefix must win. Directed cycles drive each pair together and then drive a random mix of all strobes. A behavioural model checks the selectors, the three data ports and the reload strobe on every cycle, which separates "cleared then loaded" from "kept old value".

// File: rtl/operand_select.sv
module operand_select #(
  parameter int NREG    = 16,
  parameter int W       = 16,
  parameter int BUF_REG = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pfx_src_i,
  input  logic                    pfx_dst_i,
  input  logic                    pfx_both_i,
  input  logic                    exec_i,
  input  logic                    wr_en_i,
  input  logic [$clog2(NREG)-1:0] reg_field_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [$clog2(NREG)-1:0] rd_idx_i,
  output logic [$clog2(NREG)-1:0] src_idx_o,
  output logic [$clog2(NREG)-1:0] dst_idx_o,
  output logic [W-1:0]            src_data_o,
  output logic [W-1:0]            dst_data_o,
  output logic [W-1:0]            rd_data_o,
  output logic                    reload_o
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] BUF_IDX = IW'(BUF_REG);

  logic [W-1:0]  regs [NREG];
  logic [IW-1:0] src_q, dst_q, src_d, dst_d;
  logic          wr;

  assign wr = exec_i & wr_en_i;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    if (exec_i) begin
      src_d = '0;
      dst_d = '0;
    end
    if (pfx_src_i) src_d = reg_field_i;
    if (pfx_dst_i) dst_d = reg_field_i;
    if (pfx_both_i) begin
      src_d = reg_field_i;
      dst_d = reg_field_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      if (wr) regs[dst_q] <= wdata_i;
    end
  end

  assign src_idx_o  = src_q;
  assign dst_idx_o  = dst_q;
  assign src_data_o = regs[src_q];
  assign dst_data_o = regs[dst_q];
  assign rd_data_o  = regs[rd_idx_i];
  assign reload_o   = wr & (dst_q == BUF_IDX);

  // R6
  sel_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !pfx_src_i && !pfx_dst_i && !pfx_both_i) |=> (src_idx_o == '0 && dst_idx_o == '0));

  // R2
  src_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_src_i && !pfx_both_i) |=> (src_idx_o == $past(reg_field_i)));

  // R4
  both_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_both_i |=> (src_idx_o == $past(reg_field_i) && dst_idx_o == $past(reg_field_i)));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i && !pfx_src_i && !pfx_dst_i && !pfx_both_i) |=> ($stable(src_idx_o) && $stable(dst_idx_o)));

  // R7
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && wr_en_i) |=> (regs[$past(dst_idx_o)] == $past(wdata_i)));
endmodule

// File: tb/sim_operand_select.sv
module sim_operand_select;
  logic clk = 0, rst_n = 0;
  logic ps = 0, pd = 0, pb = 0, ex = 0, we = 0;
  logic [3:0] fld = 0, rdi = 0;
  logic [15:0] wd = 0;
  logic [3:0] src_idx, dst_idx;
  logic [15:0] src_data, dst_data, rd_data;
  logic reload;

  int tests = 0, fails = 0;
  int m_regs [16];
  int m_src = 0, m_dst = 0;

  always #10 clk = ~clk;

  operand_select u0 (
    .clk(clk), .rst_n(rst_n), .pfx_src_i(ps), .pfx_dst_i(pd), .pfx_both_i(pb),
    .exec_i(ex), .wr_en_i(we), .reg_field_i(fld), .wdata_i(wd), .rd_idx_i(rdi),
    .src_idx_o(src_idx), .dst_idx_o(dst_idx), .src_data_o(src_data),
    .dst_data_o(dst_data), .rd_data_o(rd_data), .reload_o(reload)
  );

  task automatic chk(string tg, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
    end
  endtask

  task automatic cyc(string tg, bit ips, bit ipd, bit ipb, bit iex, bit iwe,
                     int f, int w, int r);
    int ns, nd;
    ps = ips; pd = ipd; pb = ipb; ex = iex; we = iwe;
    fld = 4'(f); wd = 16'(w); rdi = 4'(r);
    #2;
    chk(tg, "src_idx", int'(src_idx), m_src);
    chk(tg, "dst_idx", int'(dst_idx), m_dst);
    chk("R8", "src_data", int'(src_data), m_regs[m_src]);
    chk("R8", "dst_data", int'(dst_data), m_regs[m_dst]);
    chk(tg, "rd_data", int'(rd_data), m_regs[r]);
    chk("R9", "reload", int'(reload), (iex && iwe && m_dst == 14) ? 1 : 0);
    ns = m_src; nd = m_dst;
    if (iex) begin
      if (iwe) m_regs[m_dst] = w & 16'hFFFF;
      ns = 0; nd = 0;
    end
    if (ips) ns = f;
    if (ipd) nd = f;
    if (ipb) begin ns = f; nd = f; end
    m_src = ns; m_dst = nd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tg, int r);
    cyc(tg, 0, 0, 0, 0, 0, 0, 0, r);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state of every register and selector
    for (int i = 0; i < 16; i++) idle("R1", i);
    // R2: source prefix only
    cyc("R2", 1, 0, 0, 0, 0, 5, 0, 0);
    idle("R2", 0);
    // R3: destination prefix, then a write lands in r3
    cyc("R3", 0, 1, 0, 0, 0, 3, 0, 0);
    cyc("R7", 0, 0, 0, 1, 1, 0, 16'h1234, 3);
    idle("R7", 3);
    // R7: exec without wr_en and wr_en without exec write nothing
    cyc("R7", 0, 0, 0, 1, 0, 0, 16'hDEAD, 0);
    cyc("R7", 0, 0, 0, 0, 1, 0, 16'hBEEF, 0);
    idle("R7", 0);
    // R4: both prefix overrides single prefixes in the same cycle
    cyc("R4", 1, 1, 1, 0, 0, 9, 0, 0);
    cyc("R4", 0, 0, 0, 1, 1, 0, 16'h0909, 9);
    idle("R4", 9);
    // R5: stacking, last value wins
    cyc("R5", 1, 0, 0, 0, 0, 2, 0, 0);
    cyc("R5", 0, 1, 0, 0, 0, 7, 0, 0);
    cyc("R5", 1, 0, 0, 0, 0, 3, 0, 0);
    idle("R5", 0);
    idle("R5", 0);
    // R6: exec plus new prefix in the same cycle
    cyc("R6", 0, 0, 0, 1, 1, 0, 16'h7777, 7);
    cyc("R6", 0, 1, 0, 1, 1, 11, 16'h4242, 0);
    cyc("R6", 0, 0, 0, 1, 1, 0, 16'h1111, 11);
    idle("R6", 11);
    // R9/R10: write r14 via prefix raises reload; r15 write and use as source
    cyc("R9", 0, 0, 1, 0, 0, 14, 0, 0);
    cyc("R9", 0, 0, 0, 1, 1, 0, 16'hABCD, 14);
    cyc("R10", 0, 1, 0, 0, 0, 15, 0, 14);
    cyc("R10", 0, 0, 0, 1, 1, 0, 16'hF00D, 15);
    cyc("R10", 1, 0, 0, 0, 0, 15, 0, 15);
    idle("R10", 14);
    cyc("R10", 0, 0, 0, 1, 0, 0, 0, 15);
    // R6/R7: random mix of all strobes
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      cyc("R6", r < 15, r >= 10 && r < 25, r >= 20 && r < 30, r >= 30 && r < 65,
          $urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 65535),
          $urandom_range(0, 15));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule